// File: doc/BRIEF.md
# Synchronous SRAM Access Controller

This block is the control core of a single-port synchronous SRAM with one shared data bus. At every rising clock edge it looks at three chip selects, two address strobes and the write controls. From them it decides whether a new access begins, whether bytes are written, or whether nothing changes. It keeps the registered address, which it also hands to an external burst counter together with a one-cycle load flag. It drives per-lane write enables into a behavioural storage array and decides when the data bus may be driven.

The two strobes follow different rules. The processor strobe counts only while the first chip select is active, and it ignores the write controls at the edge that starts the access. Write qualification for that access moves to the following edge. The controller strobe starts a read or a write at once, depending on the write controls at that same edge. Reads are flow-through: the word at the registered address is on the output in the cycle right after the address is captured. The bus is released as soon as a write is seen, whatever the asynchronous output enable does.

Top module: `ssram_access_ctl`

## Requirements
- R1: A new access starts at an edge only when `sel1_n` is 0, `sel2` is 1, `sel3_n` is 0 and at least one of `pstb_n` and `cstb_n` is 0. On a start, `addr_q_o` takes `addr_i` and `addr_load_o` is 1 for the following cycle.
- R2: When `sel1_n` is 1, a low `pstb_n` starts nothing. The address is not loaded and no byte is written.
- R3: A start by `cstb_n` (with `pstb_n` high) while the write controls are inactive is a read. In the next cycle `rdata_o` equals the stored word at the captured address, and `bus_drive_o` is 1 while `rdoe_n` is 0.
- R4: A start by `cstb_n` with the write controls active writes `wdata_i` at that same edge into the address on `addr_i`.
- R5: At the edge where `pstb_n` starts an access, `allwr_n`, `bytewr_n` and `lane_n` have no effect. Nothing is written, and the stored word is readable in the next cycle.
- R6: At the edge after a `pstb_n` start, if no new start occurs and the write controls are active, `wdata_i` is written to the registered address.
- R7: `allwr_n` = 0 writes every lane, whatever `bytewr_n` and `lane_n` hold.
- R8: Otherwise lane i (bits 9i+8 down to 9i, where bit 9i+8 is the lane's parity bit) is written only when `bytewr_n` = 0 and `lane_n[i]` = 0. The parity bit goes with its lane.
- R9: `bus_drive_o` is 0 in the cycle after any write. It is also 0 during the cycle after a `pstb_n` start while the write controls are active, whatever `rdoe_n` is.
- R10: `bus_drive_o` is 0 whenever `rdoe_n` is 1.
- R11: An edge with no start and no pending `pstb_n` write performs no write and leaves `addr_q_o` unchanged, even if the write controls are active.
- R12: When both strobes are low and all selects are active, the access is treated as a `pstb_n` start, so the write controls at that edge write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| sel1_n | input | 1 | First chip select, active low; also gates the processor strobe |
| sel2 | input | 1 | Second chip select, active high |
| sel3_n | input | 1 | Third chip select, active low |
| pstb_n | input | 1 | Processor address strobe, active low |
| cstb_n | input | 1 | Controller address strobe, active low |
| allwr_n | input | 1 | Global write, active low, writes all lanes |
| bytewr_n | input | 1 | Byte write enable, active low |
| lane_n | input | BYTES | Per-lane write selects, active low |
| rdoe_n | input | 1 | Asynchronous output enable, active low |
| addr_i | input | ADDR_W | Access address |
| wdata_i | input | BYTES*LANE_W | Write data, lanes with parity |
| rdata_o | output | BYTES*LANE_W | Flow-through read data from the registered address |
| bus_drive_o | output | 1 | Data bus drive enable |
| addr_load_o | output | 1 | Load flag for the external burst counter |
| addr_q_o | output | ADDR_W | Registered address for the burst counter |

## Verification
The lane-write path is swept over every combination of global write, byte enable and the four lane selects. A read-back of each word shows whether the global override, the individual lanes and the parity bits are each decoded correctly. The start condition is swept over all 32 patterns of the three selects and the two strobes, with write controls asserted. The result in the registered address and in the memory separates processor starts, controller writes, gated strobes and no-start edges. Separate processor-strobe sequences, with and without write controls in the second cycle, tell a deferred write apart from an early write, a lost write or a write that leaks from an expired pending state.

// File: rtl/ssram_pkg.sv
package ssram_pkg;
   typedef enum logic [1:0] {
      START_NONE = 2'd0,
      START_PROC = 2'd1,
      START_CTRL = 2'd2
   } start_kind_e;
endpackage

// File: rtl/ssram_start_dec.sv
module ssram_start_dec
   import ssram_pkg::*;
(
   input  logic        sel1_n,
   input  logic        sel2,
   input  logic        sel3_n,
   input  logic        pstb_n,
   input  logic        cstb_n,
   output start_kind_e kind_o
);
   logic selected;

   // the processor strobe is only seen through the first select
   assign selected = !sel1_n && sel2 && !sel3_n;

   always_comb begin
      kind_o = START_NONE;
      if (selected && !pstb_n)
         kind_o = START_PROC;
      else if (selected && !cstb_n)
         kind_o = START_CTRL;
   end
endmodule

// File: rtl/ssram_lane_we.sv
module ssram_lane_we #(
   parameter int BYTES = 4
) (
   input  logic             allwr_n,
   input  logic             bytewr_n,
   input  logic [BYTES-1:0] lane_n,
   output logic [BYTES-1:0] lane_sel_o,
   output logic             wr_req_o
);
   for (genvar i = 0; i < BYTES; i++) begin : g_lane
      assign lane_sel_o[i] = !allwr_n || (!bytewr_n && !lane_n[i]);
   end

   assign wr_req_o = |lane_sel_o;
endmodule

// File: rtl/ssram_mem_array.sv
module ssram_mem_array #(
   parameter int ADDR_W = 4,
   parameter int BYTES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                    clk,
   input  logic [BYTES-1:0]        we,
   input  logic [ADDR_W-1:0]       waddr,
   input  logic [BYTES*LANE_W-1:0] wdata,
   input  logic [ADDR_W-1:0]       raddr,
   output logic [BYTES*LANE_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   for (genvar i = 0; i < BYTES; i++) begin : g_lane
      logic [LANE_W-1:0] store [DEPTH];

      always_ff @(posedge clk) begin
         if (we[i])
            store[waddr] <= wdata[i*LANE_W +: LANE_W];
      end

      assign rdata[i*LANE_W +: LANE_W] = store[raddr];
   end
endmodule

// File: rtl/ssram_access_ctl.sv
module ssram_access_ctl
   import ssram_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int BYTES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    sel1_n,
   input  logic                    sel2,
   input  logic                    sel3_n,
   input  logic                    pstb_n,
   input  logic                    cstb_n,
   input  logic                    allwr_n,
   input  logic                    bytewr_n,
   input  logic [BYTES-1:0]        lane_n,
   input  logic                    rdoe_n,
   input  logic [ADDR_W-1:0]       addr_i,
   input  logic [BYTES*LANE_W-1:0] wdata_i,
   output logic [BYTES*LANE_W-1:0] rdata_o,
   output logic                    bus_drive_o,
   output logic                    addr_load_o,
   output logic [ADDR_W-1:0]       addr_q_o
);
   localparam int DATA_W = BYTES * LANE_W;

   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
      $error("ssram_access_ctl: ADDR_W must lie in 1..12");
   end
   if (BYTES < 1 || LANE_W < 1) begin : g_bad_lane
      $error("ssram_access_ctl: BYTES and LANE_W must be positive");
   end

   start_kind_e       kind;
   logic [BYTES-1:0]  lane_sel;
   logic              wr_req;
   logic [BYTES-1:0]  lane_we;
   logic [ADDR_W-1:0] waddr;
   logic              ctrl_wr;
   logic              pend_wr;
   logic              pend_q;
   logic              rd_q;
   logic              start;
   logic [DATA_W-1:0] rdata;

   ssram_start_dec u_dec (
      .sel1_n (sel1_n),
      .sel2   (sel2),
      .sel3_n (sel3_n),
      .pstb_n (pstb_n),
      .cstb_n (cstb_n),
      .kind_o (kind)
   );

   ssram_lane_we #(.BYTES(BYTES)) u_we (
      .allwr_n    (allwr_n),
      .bytewr_n   (bytewr_n),
      .lane_n     (lane_n),
      .lane_sel_o (lane_sel),
      .wr_req_o   (wr_req)
   );

   assign start   = (kind != START_NONE);
   assign ctrl_wr = (kind == START_CTRL) && wr_req;
   assign pend_wr = (kind == START_NONE) && pend_q && wr_req;
   assign lane_we = (ctrl_wr || pend_wr) ? lane_sel : '0;
   assign waddr   = ctrl_wr ? addr_i : addr_q_o;

   ssram_mem_array #(.ADDR_W(ADDR_W), .BYTES(BYTES), .LANE_W(LANE_W)) u_mem (
      .clk   (clk),
      .we    (lane_we),
      .waddr (waddr),
      .wdata (wdata_i),
      .raddr (addr_q_o),
      .rdata (rdata)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         addr_q_o    <= '0;
         addr_load_o <= 1'b0;
         pend_q      <= 1'b0;
         rd_q        <= 1'b0;
      end else begin
         addr_load_o <= start;
         pend_q      <= (kind == START_PROC);
         if (start)
            addr_q_o <= addr_i;
         if (|lane_we)
            rd_q <= 1'b0;
         else if (start)
            rd_q <= 1'b1;
      end
   end

   assign rdata_o     = rdata;
   assign bus_drive_o = !rdoe_n && rd_q && !(pend_q && wr_req);
endmodule

// File: rtl/ssram_access_ctl_chk.sv
module ssram_access_ctl_chk #(
   parameter int ADDR_W = 4,
   parameter int BYTES  = 4
) (
   input logic              clk,
   input logic              rst,
   input logic              sel1_n,
   input logic              sel2,
   input logic              sel3_n,
   input logic              pstb_n,
   input logic              cstb_n,
   input logic              allwr_n,
   input logic              rdoe_n,
   input logic              bus_drive_o,
   input logic              addr_load_o,
   input logic [ADDR_W-1:0] addr_q_o,
   input logic [BYTES-1:0]  lane_we
);
   assert_start_loads_R1: assert property (@(posedge clk) disable iff (rst)
      (!sel1_n && sel2 && !sel3_n && (!pstb_n || !cstb_n)) |=> addr_load_o);

   assert_ce1_gates_R2: assert property (@(posedge clk) disable iff (rst)
      sel1_n |=> !addr_load_o);

   assert_proc_first_no_write_R5: assert property (@(posedge clk) disable iff (rst)
      (!sel1_n && sel2 && !sel3_n && !pstb_n) |-> (lane_we == '0));

   assert_global_all_lanes_R7: assert property (@(posedge clk) disable iff (rst)
      ((|lane_we) && !allwr_n) |-> (&lane_we));

   assert_write_tristates_R9: assert property (@(posedge clk) disable iff (rst)
      (|lane_we) |=> !bus_drive_o);

   assert_oe_gate_R10: assert property (@(posedge clk) disable iff (rst)
      rdoe_n |-> !bus_drive_o);

   assert_hold_addr_R11: assert property (@(posedge clk) disable iff (rst)
      !(!sel1_n && sel2 && !sel3_n && (!pstb_n || !cstb_n))
      |=> (!addr_load_o && $stable(addr_q_o)));
endmodule

bind ssram_access_ctl ssram_access_ctl_chk #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .sel1_n      (sel1_n),
   .sel2        (sel2),
   .sel3_n      (sel3_n),
   .pstb_n      (pstb_n),
   .cstb_n      (cstb_n),
   .allwr_n     (allwr_n),
   .rdoe_n      (rdoe_n),
   .bus_drive_o (bus_drive_o),
   .addr_load_o (addr_load_o),
   .addr_q_o    (addr_q_o),
   .lane_we     (lane_we)
);

// File: tb/ssram_access_ctl_bench.sv
module ssram_access_ctl_bench;
   localparam int AW = 4;
   localparam int NB = 4;
   localparam int LW = 9;
   localparam int DW = NB * LW;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          sel1_n, sel2, sel3_n, pstb_n, cstb_n;
   logic          allwr_n, bytewr_n, rdoe_n;
   logic [NB-1:0] lane_n;
   logic [AW-1:0] addr_i;
   logic [DW-1:0] wdata_i;
   logic [DW-1:0] rdata_o;
   logic          bus_drive_o, addr_load_o;
   logic [AW-1:0] addr_q_o;

   logic [DW-1:0] ref_mem [DEPTH];
   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   always #10 clk = ~clk;

   ssram_access_ctl #(.ADDR_W(AW), .BYTES(NB), .LANE_W(LW)) u_ssram_access_ctl (
      .clk(clk), .rst(rst), .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
      .pstb_n(pstb_n), .cstb_n(cstb_n), .allwr_n(allwr_n), .bytewr_n(bytewr_n),
      .lane_n(lane_n), .rdoe_n(rdoe_n), .addr_i(addr_i), .wdata_i(wdata_i),
      .rdata_o(rdata_o), .bus_drive_o(bus_drive_o), .addr_load_o(addr_load_o),
      .addr_q_o(addr_q_o)
   );

   task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                      input logic [DW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic idle();
      sel1_n = 1'b1; sel2 = 1'b0; sel3_n = 1'b1;
      pstb_n = 1'b1; cstb_n = 1'b1;
      allwr_n = 1'b1; bytewr_n = 1'b1; lane_n = '1;
      rdoe_n = 1'b0;
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   function automatic logic [NB-1:0] lanes_of(input logic g, input logic b,
                                               input logic [NB-1:0] l);
      logic [NB-1:0] m;
      for (int i = 0; i < NB; i++) m[i] = !g || (!b && !l[i]);
      return m;
   endfunction

   function automatic logic [DW-1:0] merge(input logic [DW-1:0] old,
                                           input logic [DW-1:0] nw,
                                           input logic [NB-1:0] m);
      logic [DW-1:0] r = old;
      for (int i = 0; i < NB; i++)
         if (m[i]) r[i*LW +: LW] = nw[i*LW +: LW];
      return r;
   endfunction

   function automatic logic [DW-1:0] pattern(input int k);
      return DW'(64'h9E37_79B9_7F4A_7C15 * (k + 3)) ^ DW'(k * 36'h1_0204_0811);
   endfunction

   task automatic ctl_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input logic g, input logic b, input logic [NB-1:0] l,
                            input string req);
      logic [NB-1:0] m = lanes_of(g, b, l);
      sel1_n = 1'b0; sel2 = 1'b1; sel3_n = 1'b0; pstb_n = 1'b1; cstb_n = 1'b0;
      allwr_n = g; bytewr_n = b; lane_n = l; addr_i = a; wdata_i = d;
      tick();
      ref_mem[a] = merge(ref_mem[a], d, m);
      if (m != '0)
         chk(bus_drive_o == 1'b0, {req, "/R9 bus after write"}, DW'(bus_drive_o), '0);
      idle();
   endtask

   task automatic ctl_read(input logic [AW-1:0] a, input string req);
      sel1_n = 1'b0; sel2 = 1'b1; sel3_n = 1'b0; pstb_n = 1'b1; cstb_n = 1'b0;
      allwr_n = 1'b1; bytewr_n = 1'b1; lane_n = '1; addr_i = a; rdoe_n = 1'b0;
      tick();
      chk(rdata_o === ref_mem[a] && bus_drive_o && addr_q_o == a,
          {req, " read data"}, rdata_o, ref_mem[a]);
      idle();
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      idle();
      addr_i = '0;
      wdata_i = '0;
      repeat (3) tick();
      chk(addr_q_o == '0 && !addr_load_o && !bus_drive_o, "R1 reset state",
          DW'({addr_q_o, addr_load_o, bus_drive_o}), '0);
      rst = 1'b0;
      tick();

      // R4 R7: fill every word with global writes, R3: read them back
      for (int a = 0; a < DEPTH; a++) begin
         ref_mem[a] = '0;
         ctl_write(AW'(a), pattern(a), 1'b0, 1'b1, '1, "R4 R7");
      end
      for (int a = 0; a < DEPTH; a++) ctl_read(AW'(a), "R3");

      // R7 R8: every combination of global, byte enable and lane selects
      for (int c = 0; c < 64; c++) begin
         ctl_write(AW'(c % DEPTH), pattern(100 + c), c[5], c[4], c[3:0], "R8");
         ctl_read(AW'(c % DEPTH), c[5] ? "R8 lanes" : "R7 global");
      end

      // R10: output enable gates the bus drive
      ctl_read(AW'(2), "R3");
      rdoe_n = 1'b1; #1;
      chk(!bus_drive_o, "R10 oe high", DW'(bus_drive_o), '0);
      rdoe_n = 1'b0; #1;
      chk(bus_drive_o, "R10 oe low", DW'(bus_drive_o), DW'(1));

      // R5 R6 R9: processor start with write controls deferred one edge
      sel1_n = 1'b0; sel2 = 1'b1; sel3_n = 1'b0; pstb_n = 1'b0; cstb_n = 1'b1;
      allwr_n = 1'b0; addr_i = AW'(5); wdata_i = pattern(900);
      tick();
      chk(rdata_o === ref_mem[5], "R5 no write at start edge", rdata_o, ref_mem[5]);
      chk(!bus_drive_o, "R9 pending write releases bus", DW'(bus_drive_o), '0);
      pstb_n = 1'b1; allwr_n = 1'b1; bytewr_n = 1'b0; lane_n = 4'b0101;
      wdata_i = pattern(901); addr_i = AW'(11);
      tick();
      ref_mem[5] = merge(ref_mem[5], pattern(901), 4'b1010);
      chk(!bus_drive_o && addr_q_o == AW'(5), "R9 after deferred write",
          DW'({addr_q_o, bus_drive_o}), DW'({AW'(5), 1'b0}));
      idle();
      ctl_read(AW'(5), "R6 deferred write");

      // R5 R11: processor start read, then an expired pending state
      sel1_n = 1'b0; sel2 = 1'b1; sel3_n = 1'b0; pstb_n = 1'b0; cstb_n = 1'b1;
      addr_i = AW'(6);
      tick();
      chk(bus_drive_o && rdata_o === ref_mem[6], "R5 proc read", rdata_o, ref_mem[6]);
      pstb_n = 1'b1;
      tick();
      allwr_n = 1'b0; wdata_i = pattern(902);
      tick();
      chk(addr_q_o == AW'(6) && !addr_load_o, "R11 no start holds address",
          DW'(addr_q_o), DW'(6));
      idle();
      ctl_read(AW'(6), "R11 no stray write");

      // R1 R2 R11 R12: all select and strobe patterns with global write on
      for (int s = 0; s < 32; s++) begin
         logic cs_ok, st, proc;
         ctl_read(AW'(3), "R3");
         cs_ok = !s[0] && s[1] && !s[2];
         st    = cs_ok && (!s[3] || !s[4]);
         proc  = st && !s[3];
         sel1_n = s[0]; sel2 = s[1]; sel3_n = s[2]; pstb_n = s[3]; cstb_n = s[4];
         allwr_n = 1'b0; addr_i = AW'(9); wdata_i = pattern(500 + s);
         tick();
         if (st && !proc) ref_mem[9] = pattern(500 + s);
         chk(addr_q_o == (st ? AW'(9) : AW'(3)) && addr_load_o == st,
             st ? "R1 start loads" : (s[0] && !s[3]) ? "R2 gated strobe" : "R11 hold",
             DW'({addr_q_o, addr_load_o}), DW'({st ? AW'(9) : AW'(3), st}));
         idle();
         ctl_read(AW'(9), (proc && !s[4]) ? "R12 both strobes" : "R1 R4 sweep");
         ctl_read(AW'(3), "R11 sweep");
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule